// File: doc/BRIEF.md
# SMI feature negotiation controller

This block lets boot firmware agree on a set of optional system-management-interrupt features with the platform. The platform presents a 64-bit mask of the features it supports. Firmware writes the features it wants, one byte at a time, through a small byte-wide register port, then writes an acknowledge register. If every requested bit is supported, the request is frozen as the agreed feature set and the acknowledge reads back as 1. If any bit is unsupported, the request is refused without any side effect. Once agreed, the set stays fixed until reset.

The same block watches writes to the power-management (APM) control port. Two command values only produce a one-cycle ACPI enable or ACPI disable pulse. Any other value raises an SMI, but only while the SMI enable input is high. The SMI goes to every processor when the broadcast feature (bit 0) has been agreed. Otherwise it goes only to the processor that made the write.

Top module: `smi_negotiator`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: every request byte, the acknowledge value, the agreed feature set, both ACPI pulses and all SMI request bits.
- R2: A register write to offset k (0 to 7) stores its data byte as bits [8k+7:8k] of the requested feature word (little-endian). A read of offset k returns that byte in the same cycle.
- R3: A write of any data to offset 8 (acknowledge) checks the requested word. If it has no bit outside the host mask, the word becomes the agreed set from the next cycle, and offset 8 reads 8'h01.
- R4: If the requested word has any bit outside the host mask, an acknowledge write leaves the acknowledge at 8'h00 and the agreed set unchanged.
- R5: Once offset 8 reads 8'h01, further acknowledge writes and changes to the request bytes or the host mask leave the agreed set unchanged until reset. The request bytes themselves stay writable.
- R6: An APM write of 8'hF0 drives `acpi_on_pulse` high and an APM write of 8'hF1 drives `acpi_off_pulse` high, each for exactly the one cycle after the write. Neither write raises an SMI, whatever the SMI enable.
- R7: An APM write of any other value while `smi_en` is low raises no SMI and no ACPI pulse.
- R8: An APM write of any other value while `smi_en` is high, with agreed bit 0 clear, sets only `smi_req[apm_cpu]` for the one cycle after the write.
- R9: The same write with agreed bit 0 set drives every `smi_req` bit high for the one cycle after the write.
- R10: Offsets 9 to 15 read as 8'h00, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_feat | input | 64 | Features the platform supports |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register write offset |
| reg_wdata | input | 8 | Register write data |
| reg_rd_addr | input | 4 | Register read offset |
| reg_rdata | output | 8 | Register read data (combinational) |
| apm_wr | input | 1 | APM control port write strobe |
| apm_data | input | 8 | APM control port write value |
| apm_cpu | input | 2 | Index of the processor making the APM write |
| smi_en | input | 1 | Enable for SMIs raised by APM writes |
| acpi_on_pulse | output | 1 | One-cycle pulse for the ACPI enable command |
| acpi_off_pulse | output | 1 | One-cycle pulse for the ACPI disable command |
| smi_req | output | 4 | One-cycle SMI request, one bit per processor |
| agreed_feat | output | 64 | Agreed feature set |

## Verification
The bench targets these corner cases:
- An unsupported request. A design that latched it anyway would show a non-zero agreed set and an acknowledge of 1.
- Acknowledge writes after the lock, sent with a different request and a narrower host mask. A design that re-evaluated them would change the agreed set or drop the lock.
- The two ACPI command values sent with the SMI enable high. A design that fell through to the SMI path would pulse `smi_req` alongside the ACPI output.
- Back-to-back APM writes and both agreed states of the broadcast bit. A design that routed them wrongly would send a stretched pulse, the wrong processor index, or a single-processor SMI where all four were due.

// File: rtl/smi_neg_pkg.sv
// Shared constants and types for the SMI feature negotiation controller.
// Assumes byte-wide register access and a feature word that is a whole
// number of bytes.
package smi_neg_pkg;
    localparam int FEAT_W       = 64;
    localparam int FEAT_BYTES   = FEAT_W / 8;
    localparam int REG_ADDR_W   = 4;
    localparam int ACK_OFFSET   = FEAT_BYTES;
    localparam int BCAST_BIT    = 0;
    localparam logic [7:0] CMD_ACPI_ON  = 8'hF0;
    localparam logic [7:0] CMD_ACPI_OFF = 8'hF1;

    typedef enum logic [1:0] {
        APM_NONE     = 2'd0,
        APM_ACPI_ON  = 2'd1,
        APM_ACPI_OFF = 2'd2,
        APM_SMI      = 2'd3
    } apm_kind_e;
endpackage

// File: rtl/feat_regs.sv
// Byte-addressed storage for the requested feature word.
// Offset g (below NBYTES) holds bits [8g+7:8g]. Other offsets are ignored.
// Assumes the write strobe is qualified by the caller only for timing.
module feat_regs #(
    parameter int NBYTES = 8,
    parameter int ADDR_W = 4,
    localparam int WORD_W = NBYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [WORD_W-1:0] req_word
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        // Hold one byte lane of the request; cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                req_word[8*g +: 8] <= 8'h00;
            else if (wr_en && wr_addr == ADDR_W'(g))
                req_word[8*g +: 8] <= wr_data;
        end
    end

    // R10
    high_offset_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= ADDR_W'(NBYTES)) |=> $stable(req_word));
endmodule

// File: rtl/feat_lock.sv
// Acknowledge and lock stage. On an acknowledge write it accepts the request
// only if it is a subset of the host mask. After acceptance it freezes the
// agreed set until reset. Assumes req_word and host_feat are stable registers
// or inputs at the sampling edge.
module feat_lock #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ack_wr,
    input  logic [W-1:0] req_word,
    input  logic [W-1:0] host_feat,
    output logic         locked,
    output logic [W-1:0] agreed
);
    logic legal;

    // Request is legal when no bit falls outside the host mask.
    always_comb legal = ~|(req_word & ~host_feat);

    // Latch the request once, on the first legal acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            agreed <= '0;
        end else if (ack_wr && !locked && legal) begin
            locked <= 1'b1;
            agreed <= req_word;
        end
    end

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && $stable(agreed)));
    // R3
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !locked && (req_word & ~host_feat) == '0)
            |=> (locked && agreed == $past(req_word)));
    // R4
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !locked && (req_word & ~host_feat) != '0) |=> !locked);
endmodule

// File: rtl/apm_decode.sv
// APM control port decoder. It classifies each write as ACPI on, ACPI off or
// an SMI request, and fans SMIs out to one processor or to all of them.
// All outputs are registered one-cycle pulses. Assumes apm_cpu is valid
// whenever apm_wr is high; an index at or above NUM_CPU targets nothing.
module apm_decode
    import smi_neg_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               apm_wr,
    input  logic [7:0]         apm_data,
    input  logic [CPU_W-1:0]   apm_cpu,
    input  logic               smi_en,
    input  logic               bcast,
    output logic               acpi_on,
    output logic               acpi_off,
    output logic [NUM_CPU-1:0] smi_req
);
    apm_kind_e          kind;
    logic [NUM_CPU-1:0] target;

    // Classify the current write; the SMI class requires the enable.
    always_comb begin
        kind = APM_NONE;
        if (apm_wr) begin
            if (apm_data == CMD_ACPI_ON)       kind = APM_ACPI_ON;
            else if (apm_data == CMD_ACPI_OFF) kind = APM_ACPI_OFF;
            else if (smi_en)                   kind = APM_SMI;
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        // Select this processor when broadcasting or when it made the write.
        always_comb target[c] = bcast || (apm_cpu == CPU_W'(c));
    end

    // Register the decoded pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acpi_on  <= 1'b0;
            acpi_off <= 1'b0;
            smi_req  <= '0;
        end else begin
            acpi_on  <= (kind == APM_ACPI_ON);
            acpi_off <= (kind == APM_ACPI_OFF);
            smi_req  <= (kind == APM_SMI) ? target : '0;
        end
    end

    // R6
    acpi_no_smi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acpi_on || acpi_off) |-> (smi_req == '0));
    // R6
    acpi_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acpi_on && acpi_off));
    // R7
    smi_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr && !smi_en) |=> (smi_req == '0));
    // R8
    smi_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_req != '0) |-> ($onehot(smi_req) || (&smi_req)));
    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!apm_wr) |=> (!acpi_on && !acpi_off && smi_req == '0));
endmodule

// File: rtl/smi_negotiator.sv
// Top level of the SMI feature negotiation controller. It combines the
// request byte storage, the acknowledge/lock stage and the APM decoder,
// and provides the combinational register read mux.
// Register map: offsets 0..FEAT_BYTES-1 hold the request bytes, and offset
// FEAT_BYTES is the acknowledge; the rest read zero.
module smi_negotiator
    import smi_neg_pkg::*;
#(
    parameter int NUM_CPU = 4,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [FEAT_W-1:0]     host_feat,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [7:0]            reg_wdata,
    input  logic [REG_ADDR_W-1:0] reg_rd_addr,
    output logic [7:0]            reg_rdata,
    input  logic                  apm_wr,
    input  logic [7:0]            apm_data,
    input  logic [CPU_W-1:0]      apm_cpu,
    input  logic                  smi_en,
    output logic                  acpi_on_pulse,
    output logic                  acpi_off_pulse,
    output logic [NUM_CPU-1:0]    smi_req,
    output logic [FEAT_W-1:0]     agreed_feat
);
    logic [FEAT_W-1:0] req_word;
    logic              locked;
    logic              ack_wr;

    // Decode a write to the acknowledge offset.
    always_comb ack_wr = reg_wr && (reg_addr == REG_ADDR_W'(ACK_OFFSET));

    feat_regs #(
        .NBYTES (FEAT_BYTES),
        .ADDR_W (REG_ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_addr  (reg_addr),
        .wr_data  (reg_wdata),
        .req_word (req_word)
    );

    feat_lock #(
        .W (FEAT_W)
    ) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_wr    (ack_wr),
        .req_word  (req_word),
        .host_feat (host_feat),
        .locked    (locked),
        .agreed    (agreed_feat)
    );

    apm_decode #(
        .NUM_CPU (NUM_CPU),
        .CPU_W   (CPU_W)
    ) u_apm (
        .clk      (clk),
        .rst_n    (rst_n),
        .apm_wr   (apm_wr),
        .apm_data (apm_data),
        .apm_cpu  (apm_cpu),
        .smi_en   (smi_en),
        .bcast    (agreed_feat[BCAST_BIT]),
        .acpi_on  (acpi_on_pulse),
        .acpi_off (acpi_off_pulse),
        .smi_req  (smi_req)
    );

    // Return the addressed request byte, the acknowledge flag, or zero.
    always_comb begin
        reg_rdata = 8'h00;
        for (int b = 0; b < FEAT_BYTES; b++) begin
            if (reg_rd_addr == REG_ADDR_W'(b))
                reg_rdata = req_word[8*b +: 8];
        end
        if (reg_rd_addr == REG_ADDR_W'(ACK_OFFSET))
            reg_rdata = {7'b0, locked};
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (agreed_feat == '0 && !acpi_on_pulse && !acpi_off_pulse
                    && smi_req == '0));
    // R9
    bcast_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr && smi_en && apm_data != CMD_ACPI_ON && apm_data != CMD_ACPI_OFF
         && agreed_feat[BCAST_BIT]) |=> (&smi_req));
endmodule

// File: tb/smi_negotiator_test.sv
module smi_negotiator_test;
    localparam int NCPU = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] host_feat = 64'h0000_0000_0000_0013;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [3:0]  reg_rd_addr = '0;
    logic [7:0]  reg_rdata;
    logic        apm_wr = 1'b0;
    logic [7:0]  apm_data = '0;
    logic [1:0]  apm_cpu = '0;
    logic        smi_en = 1'b0;
    logic        acpi_on_pulse, acpi_off_pulse;
    logic [3:0]  smi_req;
    logic [63:0] agreed_feat;

    smi_negotiator #(.NUM_CPU(NCPU)) uut (
        .clk(clk), .rst_n(rst_n), .host_feat(host_feat),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata),
        .apm_wr(apm_wr), .apm_data(apm_data), .apm_cpu(apm_cpu),
        .smi_en(smi_en), .acpi_on_pulse(acpi_on_pulse),
        .acpi_off_pulse(acpi_off_pulse), .smi_req(smi_req),
        .agreed_feat(agreed_feat)
    );

    always #10 clk = ~clk;  // 50 MHz

    // Behavioural reference state.
    byte unsigned m_bytes [8];
    bit           m_ack;
    logic [63:0]  m_agreed;
    bit           m_on, m_off;
    logic [3:0]   m_smi;

    int    applied = 0;
    int    miscompares = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_req = "R1";

    function automatic logic [63:0] model_word();
        logic [63:0] w = '0;
        for (int i = 0; i < 8; i++) w = w | (64'(m_bytes[i]) << (i * 8));
        return w;
    endfunction

    function automatic logic [7:0] model_read(input logic [3:0] a);
        if (a < 8) return m_bytes[a];
        if (a == 8) return m_ack ? 8'h01 : 8'h00;
        return 8'h00;
    endfunction

    // Reference model: update on each rising edge from the stable inputs.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_bytes[i] <= 0;
            m_ack <= 0; m_agreed <= '0; m_on <= 0; m_off <= 0; m_smi <= '0;
        end else begin
            if (reg_wr && reg_addr < 8) m_bytes[reg_addr] <= reg_wdata;
            if (reg_wr && reg_addr == 8 && !m_ack) begin
                if ((model_word() & ~host_feat) == 64'd0) begin
                    m_ack <= 1; m_agreed <= model_word();
                end
            end
            m_on  <= apm_wr && apm_data == 8'hF0;
            m_off <= apm_wr && apm_data == 8'hF1;
            if (apm_wr && smi_en && apm_data != 8'hF0 && apm_data != 8'hF1)
                m_smi <= m_agreed[0] ? 4'hF : (4'b0001 << apm_cpu);
            else
                m_smi <= '0;
        end
    end

    task automatic cmp(input string what, input logic [63:0] act, input logic [63:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            cmp("smi_req", 64'(smi_req), 64'(m_smi));
            cmp("acpi_on", 64'(acpi_on_pulse), 64'(m_on));
            cmp("acpi_off", 64'(acpi_off_pulse), 64'(m_off));
            cmp("agreed", agreed_feat, m_agreed);
            cmp("rdata", 64'(reg_rdata), 64'(model_read(reg_rd_addr)));
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_wr = 0;
    endtask

    task automatic wr_word(input logic [63:0] w);
        for (int i = 0; i < 8; i++) wr_reg(4'(i), w[8*i +: 8]);
    endtask

    task automatic wr_apm(input logic [7:0] d, input logic [1:0] c);
        apm_wr = 1; apm_data = d; apm_cpu = c;
        tick(1);
        apm_wr = 0;
    endtask

    task automatic sweep_reads();
        for (int a = 0; a < 16; a++) begin reg_rd_addr = 4'(a); tick(1); end
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        cur_req = "R1"; sweep_reads();

        cur_req = "R2";
        wr_word(64'h8877_6655_4433_2211);
        sweep_reads();
        reg_rd_addr = 4'd3; wr_reg(4'd3, 8'hA5); tick(1);

        cur_req = "R10";
        wr_reg(4'd9, 8'hFF); wr_reg(4'd15, 8'h5A); wr_reg(4'd12, 8'h01);
        sweep_reads();

        cur_req = "R4";
        wr_word(64'h0000_0000_0000_0023);   // bit 5 unsupported
        reg_rd_addr = 4'd8;
        wr_reg(4'd8, 8'h01); tick(2);
        wr_word(64'h8000_0000_0000_0000);   // top bit unsupported
        reg_rd_addr = 4'd8; wr_reg(4'd8, 8'hFF); tick(2);

        cur_req = "R7";
        smi_en = 0; wr_apm(8'h42, 2'd1); tick(1);
        cur_req = "R8";
        smi_en = 1; wr_apm(8'h42, 2'd2); tick(1);
        wr_apm(8'h00, 2'd0); wr_apm(8'hF2, 2'd3); wr_apm(8'hEF, 2'd1); tick(1);
        cur_req = "R6";
        wr_apm(8'hF0, 2'd1); wr_apm(8'hF1, 2'd2); wr_apm(8'hF0, 2'd0); tick(1);
        smi_en = 0; wr_apm(8'hF1, 2'd3); smi_en = 1; tick(1);

        cur_req = "R3";
        wr_word(64'h0000_0000_0000_0012);
        reg_rd_addr = 4'd8; wr_reg(4'd8, 8'h00); tick(2);
        cur_req = "R8";
        wr_apm(8'h77, 2'd3); wr_apm(8'h77, 2'd0); tick(1);

        cur_req = "R5";
        wr_word(64'h0000_0000_0000_0001);
        wr_reg(4'd8, 8'h01); tick(1);
        host_feat = 64'h0; wr_reg(4'd8, 8'h01); tick(1);
        host_feat = 64'h0000_0000_0000_0013;
        sweep_reads();
        wr_apm(8'h10, 2'd1); tick(2);

        cur_req = "R1";
        rst_n = 0; tick(2); rst_n = 1; sweep_reads();

        cur_req = "R3";
        wr_word(64'h0000_0000_0000_0013);
        reg_rd_addr = 4'd8; wr_reg(4'd8, 8'h01); tick(2);
        cur_req = "R9";
        wr_apm(8'h55, 2'd2); wr_apm(8'h56, 2'd0); tick(1);
        smi_en = 0; wr_apm(8'h55, 2'd1); smi_en = 1; tick(1);
        cur_req = "R6";
        wr_apm(8'hF0, 2'd2); wr_apm(8'hF1, 2'd0); tick(2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a miscompare.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end
endmodule